// File: doc/BRIEF.md
# Memory-Mapped Address Decoder

This block sits between a processor's load/store port and three kinds of target: a read-only memory, a random-access memory and a window of device registers. It classifies every request by address alone, so an ordinary load or store reaches a device register exactly as it reaches memory. It raises one select strobe, steers the matching read data back to the processor, and flags a bus error for any access it cannot legally carry out.

The whole response is combinational. Select strobes, the error flag and read data all belong to the same cycle as the request. Register writes take effect on the following clock edge. Inside the device window sits a small register stub with three registers. The first is a status word that follows two device flags and ignores stores. The second is a control word with read/write bits and one write-only bit that fires a pulse. The third is a plain data word.

Top module: `mmio_decoder`

## Requirements
- R1: A valid, error-free request with address 0x00000000..0x0000FFFF asserts romSel only, and rspRdata equals romRdata in the same cycle.
- R2: A valid, error-free request with address 0x00010000..0xFFFEFFFF asserts ramSel only, and rspRdata equals ramRdata in the same cycle.
- R3: A valid, error-free request with address 0xFFFF0000..0xFFFFFFFF asserts ioSel only. Loads and stores are routed identically, and at most one select is ever high.
- R4: A store to the ROM range asserts rspErr and no select.
- R5: Byte enable 4'b1111 is legal only with reqAddr[1:0]==0. A single-bit enable is legal only when its set bit index equals reqAddr[1:0]. Any other pattern asserts rspErr, asserts no select, and changes no register.
- R6: When rspErr is high, or reqValid is low, all selects are low and rspRdata is zero. rspErr is never high without reqValid.
- R7: The status register at window offset 0x0 reads bit0 = devBusy and bit1 = devReady, as captured at the previous clock edge, with all other bits zero. Stores to it are accepted and ignored.
- R8: The control register at window offset 0x4 holds bits [7:0] as read/write through byte lane 0. It reads back through rspRdata and drives ctrlOut.
- R9: Control bit 31 is write-only. A store to offset 0x4 with reqByteEn[3] set and reqWdata[31]=1 raises ctrlKick for the one cycle after the write edge. Bit 31 always reads as 0.
- R10: The data register at window offset 0x8 is 32 bits wide, written per byte lane under reqByteEn, read back whole and driven on dataOut.
- R11: Any window offset at or above 0xC asserts rspErr, reads zero, asserts no ioSel and changes no register.
- R12: Reset clears ctrlOut, dataOut, ctrlKick and the captured status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address |
| reqByteEn | input | 4 | Byte-lane enables |
| reqWdata | input | 32 | Store data |
| romRdata | input | 32 | Read data from the ROM |
| ramRdata | input | 32 | Read data from the RAM |
| devBusy | input | 1 | Device busy flag |
| devReady | input | 1 | Device ready flag |
| romSel | output | 1 | ROM select strobe |
| ramSel | output | 1 | RAM select strobe |
| ioSel | output | 1 | Register window select strobe |
| rspErr | output | 1 | Bus error for this request |
| rspRdata | output | 32 | Read data returned to the processor |
| ctrlOut | output | 8 | Read/write control bits |
| ctrlKick | output | 1 | One-cycle pulse from the write-only control bit |
| dataOut | output | 32 | Data register contents |

## Verification
The hardest condition to reach is the overlap of an enable pattern that is legal on its own with an address or target that makes the access illegal. Examples are a correctly aligned byte store into the ROM, and a full-word store to an unmapped window offset carrying a kick bit that must not fire. The stimulus gets there by sweeping every byte-enable value against every low address pair, for loads and stores, at addresses on each region boundary and at each window register. A bench model of the register stub tracks every accepted write, so each later read-back, each kick pulse and each captured status value is predicted one edge ahead.

// File: rtl/mmio_decoder_pkg.sv
package mmio_decoder_pkg;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_DATA   = 2'd2,
    REG_NONE   = 2'd3
  } ioreg_e;

  typedef struct packed {
    logic       romSel;
    logic       ramSel;
    logic       ioSel;
    logic       err;
    ioreg_e     regSel;
    logic       regWr;
    logic [3:0] laneWr;
  } strobe_t;

endpackage

// File: rtl/mmio_decoder_ctrl.sv
module mmio_decoder_ctrl
  import mmio_decoder_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ROM_BYTES = 65536,
  parameter int IO_BYTES  = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqByteEn,
  output strobe_t           strb
);

  localparam int LANES    = DATA_W / 8;
  localparam int LANE_W   = $clog2(LANES);
  localparam int IO_OFF_W = $clog2(IO_BYTES);
  localparam int IDX_W    = IO_OFF_W - LANE_W;
  localparam int IO_REGS  = 3;
  localparam logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(ROM_BYTES);
  localparam logic [ADDR_W-1:0] IO_BASE   = ~(ADDR_W'(IO_BYTES) - ADDR_W'(1));

  logic [LANE_W-1:0] laneAddr;
  logic [LANES-1:0]  laneHit;
  logic [IDX_W-1:0]  regIdx;
  logic inRom, inIo, inRam;
  logic fullOk, singleOk, enOk, regKnown, romStore, accErr, go;
  ioreg_e regSel;

  assign laneAddr = reqAddr[LANE_W-1:0];
  assign regIdx   = reqAddr[IO_OFF_W-1:LANE_W];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneHit[i] = (laneAddr == LANE_W'(i));
  end

  assign inRom = (reqAddr < ROM_LIMIT);
  assign inIo  = (reqAddr >= IO_BASE);
  assign inRam = !inRom && !inIo;

  assign fullOk   = (&reqByteEn) && (laneAddr == '0);
  assign singleOk = (reqByteEn == laneHit);
  assign enOk     = fullOk || singleOk;

  assign regKnown = (regIdx < IDX_W'(IO_REGS));
  assign romStore = reqWrite && inRom;
  assign accErr   = !enOk || romStore || (inIo && !regKnown);
  assign go       = reqValid && !accErr;

  always_comb begin
    case (regIdx)
      IDX_W'(0): regSel = REG_STATUS;
      IDX_W'(1): regSel = REG_CTRL;
      IDX_W'(2): regSel = REG_DATA;
      default:   regSel = REG_NONE;
    endcase
  end

  always_comb begin
    strb        = '0;
    strb.err    = reqValid && accErr;
    strb.romSel = go && inRom;
    strb.ramSel = go && inRam;
    strb.ioSel  = go && inIo;
    strb.regSel = inIo ? regSel : REG_NONE;
    strb.regWr  = go && inIo && reqWrite;
    strb.laneWr = (go && inIo && reqWrite) ? reqByteEn : 4'b0000;
  end

  // R3: never more than one target selected
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.romSel, strb.ramSel, strb.ioSel}));

  // R4: a store into the ROM range is refused
  a_r4_rom_store_err: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr < ROM_LIMIT) |-> (strb.err && !strb.romSel));

  // R5: enable patterns with two or three lanes, or none, are always errors
  a_r5_bad_enable: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $countones(reqByteEn) != 1 && $countones(reqByteEn) != LANES) |-> strb.err);

  // R11: the window select only reaches the three implemented registers
  a_r11_mapped_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.ioSel |-> (reqAddr[IO_OFF_W-1:LANE_W] < IDX_W'(IO_REGS)));

  // R6: no error without a request
  a_r6_err_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!strb.err && !strb.romSel && !strb.ramSel && !strb.ioSel));

endmodule

// File: rtl/mmio_decoder_dp.sv
module mmio_decoder_dp
  import mmio_decoder_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CTRL_RW_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    romRdata,
  input  logic [DATA_W-1:0]    ramRdata,
  input  logic                 devBusy,
  input  logic                 devReady,
  output logic [DATA_W-1:0]    rspRdata,
  output logic [CTRL_RW_W-1:0] ctrlOut,
  output logic                 ctrlKick,
  output logic [DATA_W-1:0]    dataOut
);

  localparam int LANES = DATA_W / 8;

  logic [1:0]           statusQ;
  logic [CTRL_RW_W-1:0] ctrlQ;
  logic                 kickQ;
  logic [DATA_W-1:0]    dataQ;
  logic [DATA_W-1:0]    regRd;
  logic                 ctrlWr, dataWr;

  assign ctrlWr = strb.regWr && (strb.regSel == REG_CTRL);
  assign dataWr = strb.regWr && (strb.regSel == REG_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      ctrlQ   <= '0;
      kickQ   <= 1'b0;
    end else begin
      statusQ <= {devReady, devBusy};
      if (ctrlWr && strb.laneWr[0]) ctrlQ <= reqWdata[CTRL_RW_W-1:0];
      kickQ <= ctrlWr && strb.laneWr[LANES-1] && reqWdata[DATA_W-1];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_dlane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneQ <= '0;
      else if (dataWr && strb.laneWr[i]) laneQ <= reqWdata[8*i +: 8];
    end
    assign dataQ[8*i +: 8] = laneQ;
  end

  always_comb begin
    case (strb.regSel)
      REG_STATUS: regRd = {{(DATA_W-2){1'b0}}, statusQ};
      REG_CTRL:   regRd = DATA_W'(ctrlQ);
      REG_DATA:   regRd = dataQ;
      default:    regRd = '0;
    endcase
  end

  always_comb begin
    if (strb.romSel)      rspRdata = romRdata;
    else if (strb.ramSel) rspRdata = ramRdata;
    else if (strb.ioSel)  rspRdata = regRd;
    else                  rspRdata = '0;
  end

  assign ctrlOut  = ctrlQ;
  assign ctrlKick = kickQ;
  assign dataOut  = dataQ;

  // R6: an errored access returns zero
  a_r6_err_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |-> (rspRdata == '0));

  // R7: status follows the device flags one edge late
  a_r7_status_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusQ == $past({devReady, devBusy})));

  // R8, R10: registers hold without an accepted store
  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> ($stable(ctrlQ) && $stable(dataQ)));

  // R9: a kick pulse always follows an accepted window store
  a_r9_kick_after_store: assert property (@(posedge clk) disable iff (!rstN)
    kickQ |-> $past(strb.regWr));

endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
  import mmio_decoder_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ROM_BYTES = 65536,
  parameter int IO_BYTES  = 65536,
  parameter int CTRL_RW_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [3:0]           reqByteEn,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    romRdata,
  input  logic [DATA_W-1:0]    ramRdata,
  input  logic                 devBusy,
  input  logic                 devReady,
  output logic                 romSel,
  output logic                 ramSel,
  output logic                 ioSel,
  output logic                 rspErr,
  output logic [DATA_W-1:0]    rspRdata,
  output logic [CTRL_RW_W-1:0] ctrlOut,
  output logic                 ctrlKick,
  output logic [DATA_W-1:0]    dataOut
);

  strobe_t strb;

  mmio_decoder_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BYTES(ROM_BYTES), .IO_BYTES(IO_BYTES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .strb(strb)
  );

  mmio_decoder_dp #(
    .DATA_W(DATA_W), .CTRL_RW_W(CTRL_RW_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata),
    .romRdata(romRdata), .ramRdata(ramRdata), .devBusy(devBusy), .devReady(devReady),
    .rspRdata(rspRdata), .ctrlOut(ctrlOut), .ctrlKick(ctrlKick), .dataOut(dataOut)
  );

  assign romSel = strb.romSel;
  assign ramSel = strb.ramSel;
  assign ioSel  = strb.ioSel;
  assign rspErr = strb.err;

endmodule

// File: tb/mmio_decoder_tb_top.sv
module mmio_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0, romRdata = '0, ramRdata = '0;
  logic [3:0]  reqByteEn = '0;
  logic        devBusy = 1'b0, devReady = 1'b0;
  logic        romSel, ramSel, ioSel, rspErr, ctrlKick;
  logic [31:0] rspRdata, dataOut;
  logic [7:0]  ctrlOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_decoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .romRdata(romRdata), .ramRdata(ramRdata), .devBusy(devBusy), .devReady(devReady),
    .romSel(romSel), .ramSel(ramSel), .ioSel(ioSel), .rspErr(rspErr),
    .rspRdata(rspRdata), .ctrlOut(ctrlOut), .ctrlKick(ctrlKick), .dataOut(dataOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic enLegal(input logic [1:0] lo, input logic [3:0] be);
    return (be == 4'hF && lo == 2'd0) || (be == (4'b0001 << lo));
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] bases [12];
    logic [1:0]  mStatus;
    logic [7:0]  mCtrl;
    logic [31:0] mData;
    logic        mKick;
    int          step;
    bases = '{32'h0000_0000, 32'h0000_0004, 32'h0000_FFFC, 32'h0001_0000,
              32'h1234_5678, 32'h8000_0000, 32'hFFFE_FFFC, 32'hFFFF_0000,
              32'hFFFF_0004, 32'hFFFF_0008, 32'hFFFF_000C, 32'hFFFF_FFFC};

    // R12: reset state
    repeat (2) @(negedge clk);
    chk("R12 ctrlOut", {24'h0, ctrlOut}, 32'h0);
    chk("R12 dataOut", dataOut, 32'h0);
    chk("R12 ctrlKick", {31'h0, ctrlKick}, 32'h0);
    rstN = 1'b1;
    devBusy = 1'b0; devReady = 1'b1;
    @(negedge clk);
    mStatus = 2'b10; mCtrl = '0; mData = '0; mKick = 1'b0;

    // R6: idle bus
    chk("R6 idle", {27'h0, romSel, ramSel, ioSel, rspErr, 1'b0}, 32'h0);
    chk("R6 idle rdata", rspRdata, 32'h0);

    step = 0;
    for (int a = 0; a < 12; a++) begin
      for (int w = 0; w < 2; w++) begin
        for (int be = 0; be < 16; be++) begin
          for (int lo = 0; lo < 4; lo++) begin
            logic [31:0] addr, expRd;
            logic eRom, eRam, eIo, eErr, enOk, romW, unm, go;
            string tag;
            @(negedge clk);
            step++;
            addr      = bases[a] | 32'(lo);
            reqValid  = 1'b1;
            reqWrite  = w[0];
            reqAddr   = addr;
            reqByteEn = 4'(be);
            reqWdata  = 32'h9E37_79B9 * 32'(step);
            romRdata  = 32'h0F0F_0000 ^ 32'(step);
            ramRdata  = 32'hC0DE_0000 ^ (32'(step) * 3);
            devBusy   = step[0];
            devReady  = step[2];
            #1;
            // R9: pulse from the previous step's store
            chk("R9 ctrlKick", {31'h0, ctrlKick}, {31'h0, mKick});

            enOk = enLegal(2'(lo), 4'(be));
            romW = w[0] && (addr < 32'h0001_0000);
            eIo  = (addr >= 32'hFFFF_0000);
            unm  = eIo && (addr[15:2] > 14'd2);
            eErr = !enOk || romW || unm;
            go   = !eErr;
            eRom = go && (addr < 32'h0001_0000);
            eRam = go && !eIo && (addr >= 32'h0001_0000);
            eIo  = go && eIo;

            if (!enOk)     tag = "R5";
            else if (romW) tag = "R4";
            else if (unm)  tag = "R11";
            else if (eRom) tag = "R1";
            else if (eRam) tag = "R2";
            else if (addr[15:2] == 14'd0) tag = "R3/R7";
            else if (addr[15:2] == 14'd1) tag = "R3/R8/R9";
            else tag = "R3/R10";

            expRd = 32'h0;
            if (eRom) expRd = romRdata;
            else if (eRam) expRd = ramRdata;
            else if (eIo) begin
              case (addr[15:2])
                14'd0:   expRd = {30'h0, mStatus};
                14'd1:   expRd = {24'h0, mCtrl};
                default: expRd = mData;
              endcase
            end
            chk(tag, {28'h0, romSel, ramSel, ioSel, rspErr}, {28'h0, eRom, eRam, eIo, eErr});
            chk(eErr ? "R6" : tag, rspRdata, expRd);

            // model the coming edge
            mKick = 1'b0;
            if (eIo && w[0] && addr[15:2] == 14'd1) begin
              if (be[0]) mCtrl = reqWdata[7:0];
              mKick = be[3] && reqWdata[31];
            end
            if (eIo && w[0] && addr[15:2] == 14'd2) begin
              for (int i = 0; i < 4; i++)
                if (be[i]) mData[8*i +: 8] = reqWdata[8*i +: 8];
            end
            mStatus = {devReady, devBusy};
          end
        end
      end
    end

    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk("R9 final kick", {31'h0, ctrlKick}, {31'h0, mKick});
    chk("R8 ctrlOut", {24'h0, ctrlOut}, {24'h0, mCtrl});
    chk("R10 dataOut", dataOut, mData);
    chk("R6 idle again", {28'h0, romSel, ramSel, ioSel, rspErr}, 32'h0);
    finish_run();
  end

endmodule